// File: doc/BRIEF.md
# Four-Level Preemptive Interrupt Priority Arbiter

This block decides which interrupt request a processor core should service next. It watches 32 external request lines and 16 internal system exception lines, 48 sources in all. Each source has a two-bit priority level. A smaller level is more urgent. Level 0 is the most urgent and level 3 the least. The levels are held in twelve 32-bit words on a simple word-wide register bus. Each word covers four sources with one byte per source. Only the top two bits of each byte are stored.

Vector numbers run from 0 to 15 for the system slots and from 16 to 47 for the external lines. External line j is vector 16+j.

A request is taken only if its level is strictly more urgent than the level of the handler that is running. When a request is taken, the block does three things:
- it emits a one-cycle take pulse together with the vector number;
- it saves the running level on a nesting stack;
- it reports the new handler's level as the active level.

The core signals handler exit with a one-cycle strobe. The exit pops the saved level back into the active level.

When no handler is running, the active level reads 4 (the idle level), which every level 0 to 3 can preempt.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset every stored priority field is 0, the active level reads 4 (idle), the take pulse is low and every register word reads zero.
- R2: A write with all four byte enables set stores bits [7:6] of each byte into that byte's field. Reading the word back returns those two bits in place, with bits [5:0] of every byte zero.
- R3: A write whose byte enables are not all set (any value other than 4'hF) changes no field.
- R4: Word indices 0 to 7 hold external lines 4w..4w+3 (vectors 16+4w+k, byte k). Word indices 8 to 11 hold system slots 4(w-8)..4(w-8)+3 (vectors 4(w-8)+k). The system tick is slot 15, which is byte 3 of word 11. Indices 12 to 15 read zero and ignore writes.
- R5: A winning request sampled at one rising edge produces a one-cycle take pulse and its vector number right after that edge. Among pending requests the most urgent level wins.
- R6: When several pending requests share the most urgent level, the lowest vector number wins.
- R7: A request is taken only if its level is strictly smaller than the active level. A request at an equal or less urgent level stays unserviced while the active level is unchanged.
- R8: Taking a request saves the current active level on the nesting stack and makes the winner's level the active level, in the same cycle as the take pulse.
- R9: An exit strobe restores the active level saved at the most recent entry. The stack holds up to four nested entries. An exit strobe with no saved entry leaves the active level at 4.
- R10: No request is taken on the edge that samples an exit strobe. A pending request is judged against the restored level on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_be | input | 4 | Byte enables of the write |
| bus_addr | input | 4 | Word index of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |
| ext_req | input | 32 | External request lines, level sensitive |
| sys_req | input | 16 | System exception request lines, level sensitive |
| handler_exit | input | 1 | One-cycle strobe marking the end of the running handler |
| take_pulse | output | 1 | One-cycle strobe: a request has been taken |
| take_vec | output | 6 | Vector number of the taken request, valid with take_pulse |
| active_lvl | output | 3 | Level of the running handler, 4 when none runs |

## Verification
A handler exit and a new preemption can fall in the same cycle. This happens when an exit strobe arrives while a request is pending at a level the restored priority would admit.

The bench provokes this case in three steps:
1. It nests three handlers.
2. It raises a request at the same level as the innermost handler, which therefore must wait.
3. It strobes exit while that request is still held.

The judgement is made on two consecutive cycles. On the exit edge the take pulse must stay low and the active level must drop back to the saved value. On the next edge the waiting request must be taken with its own vector and level.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    // Default geometry of the arbiter
    localparam int unsigned DEF_NUM_EXT    = 32;
    localparam int unsigned DEF_NUM_SYS    = 16;
    localparam int unsigned DEF_PRIO_W     = 2;
    localparam int unsigned DEF_NEST_DEPTH = 4;
    localparam int unsigned DEF_ADDR_W     = 4;
    localparam int unsigned BYTES_PER_WORD = 4;

    // Kind of register bus access seen in a cycle
    typedef enum logic [1:0] {
        ACC_NONE    = 2'd0,
        ACC_WORD    = 2'd1,
        ACC_PARTIAL = 2'd2,
        ACC_OUTSIDE = 2'd3
    } bus_acc_e;

    // Source index held by byte k of register word w.
    // Words below ext_words hold external lines; the rest hold system slots.
    function automatic int unsigned src_of(input int unsigned w,
                                           input int unsigned k,
                                           input int unsigned ext_words,
                                           input int unsigned num_sys);
        if (w < ext_words)
            return num_sys + BYTES_PER_WORD * w + k;
        return BYTES_PER_WORD * (w - ext_words) + k;
    endfunction

endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_arb_pkg::*;
#(
    parameter int unsigned NUM_EXT = DEF_NUM_EXT,
    parameter int unsigned NUM_SYS = DEF_NUM_SYS,
    parameter int unsigned PRIO_W  = DEF_PRIO_W,
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    localparam int unsigned NUM_SRC = NUM_EXT + NUM_SYS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_we,
    input  logic [3:0]                 bus_be,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    output logic [NUM_SRC*PRIO_W-1:0]  prio_flat
);
    localparam int unsigned EXT_WORDS = NUM_EXT / BYTES_PER_WORD;
    localparam int unsigned NUM_WORDS = NUM_SRC / BYTES_PER_WORD;

    logic [PRIO_W-1:0] prio_q [NUM_SRC];
    bus_acc_e          acc;

    // Classify the access: only in-range full-word writes are accepted
    always_comb begin
        if (!bus_we)
            acc = ACC_NONE;
        else if (32'(bus_addr) >= NUM_WORDS)
            acc = ACC_OUTSIDE;
        else if (bus_be != 4'hF)
            acc = ACC_PARTIAL;
        else
            acc = ACC_WORD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SRC; s++)
                prio_q[s] <= '0;
        end else if (acc == ACC_WORD) begin
            for (int k = 0; k < BYTES_PER_WORD; k++)
                prio_q[src_of(32'(bus_addr), k, EXT_WORDS, NUM_SYS)]
                    <= bus_wdata[8*k+7 -: PRIO_W];
        end
    end

    // Readback: stored bits sit at the top of each byte, the rest reads zero
    always_comb begin
        bus_rdata = '0;
        if (32'(bus_addr) < NUM_WORDS) begin
            for (int k = 0; k < BYTES_PER_WORD; k++)
                bus_rdata[8*k+7 -: PRIO_W] =
                    prio_q[src_of(32'(bus_addr), k, EXT_WORDS, NUM_SYS)];
        end
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_flat
        assign prio_flat[s*PRIO_W +: PRIO_W] = prio_q[s];
    end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter  int unsigned NUM_SRC = 48,
    parameter  int unsigned PRIO_W  = 2,
    localparam int unsigned VEC_W   = $clog2(NUM_SRC),
    localparam int unsigned LVL_W   = PRIO_W + 1
) (
    input  logic [NUM_SRC-1:0]         req,
    input  logic [NUM_SRC*PRIO_W-1:0]  prio_flat,
    output logic                       win_valid,
    output logic [VEC_W-1:0]           win_vec,
    output logic [LVL_W-1:0]           win_lvl
);
    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
        logic [LVL_W-1:0] lvl;
    } cand_t;

    cand_t best;

    // Scan upward; only a strictly better level replaces the holder,
    // so on equal levels the lowest vector stays
    always_comb begin
        best       = '0;
        best.lvl   = LVL_W'(1 << PRIO_W);
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i] && ({1'b0, prio_flat[i*PRIO_W +: PRIO_W]} < best.lvl)) begin
                best.valid = 1'b1;
                best.vec   = VEC_W'(i);
                best.lvl   = {1'b0, prio_flat[i*PRIO_W +: PRIO_W]};
            end
        end
    end

    assign win_valid = best.valid;
    assign win_vec   = best.vec;
    assign win_lvl   = best.lvl;

endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
    parameter  int unsigned DEPTH  = 4,
    parameter  int unsigned LVL_W  = 3,
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
    localparam int unsigned IDLE   = (1 << (LVL_W - 1))
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [LVL_W-1:0] push_lvl,
    input  logic             pop,
    output logic [LVL_W-1:0] active_lvl,
    output logic             full
);
    logic [LVL_W-1:0] saved_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [LVL_W-1:0] act_q;

    assign full       = (32'(cnt_q) == DEPTH);
    assign active_lvl = act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= LVL_W'(IDLE);
            for (int d = 0; d < DEPTH; d++)
                saved_q[d] <= LVL_W'(IDLE);
        end else if (pop) begin
            if (cnt_q != '0) begin
                act_q <= saved_q[cnt_q - 1'b1];
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (push && !full) begin
            saved_q[cnt_q] <= act_q;
            act_q          <= push_lvl;
            cnt_q          <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter  int unsigned NUM_EXT    = DEF_NUM_EXT,
    parameter  int unsigned NUM_SYS    = DEF_NUM_SYS,
    parameter  int unsigned PRIO_W     = DEF_PRIO_W,
    parameter  int unsigned NEST_DEPTH = DEF_NEST_DEPTH,
    parameter  int unsigned ADDR_W     = DEF_ADDR_W,
    localparam int unsigned NUM_SRC    = NUM_EXT + NUM_SYS,
    localparam int unsigned VEC_W      = $clog2(NUM_SRC),
    localparam int unsigned LVL_W      = PRIO_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [3:0]         bus_be,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_EXT-1:0] ext_req,
    input  logic [NUM_SYS-1:0] sys_req,
    input  logic               handler_exit,
    output logic               take_pulse,
    output logic [VEC_W-1:0]   take_vec,
    output logic [LVL_W-1:0]   active_lvl
);
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic                      win_valid;
    logic [VEC_W-1:0]          win_vec;
    logic [LVL_W-1:0]          win_lvl;
    logic                      stk_full;
    logic                      preempt;
    logic                      take_q;
    logic [VEC_W-1:0]          vec_q;

    irq_prio_regs #(
        .NUM_EXT (NUM_EXT),
        .NUM_SYS (NUM_SYS),
        .PRIO_W  (PRIO_W),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_be    (bus_be),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .prio_flat (prio_flat)
    );

    irq_pick #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W)
    ) u_pick (
        .req       ({ext_req, sys_req}),
        .prio_flat (prio_flat),
        .win_valid (win_valid),
        .win_vec   (win_vec),
        .win_lvl   (win_lvl)
    );

    // Exit wins the cycle; a new entry needs strictly higher urgency
    assign preempt = win_valid && (win_lvl < active_lvl) && !handler_exit && !stk_full;

    irq_nest_stack #(
        .DEPTH (NEST_DEPTH),
        .LVL_W (LVL_W)
    ) u_stack (
        .clk        (clk),
        .rst        (rst),
        .push       (preempt),
        .push_lvl   (win_lvl),
        .pop        (handler_exit),
        .active_lvl (active_lvl),
        .full       (stk_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            take_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            take_q <= preempt;
            if (preempt)
                vec_q <= win_vec;
        end
    end

    assign take_pulse = take_q;
    assign take_vec   = vec_q;

endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
    parameter  int unsigned NUM_EXT = 32,
    parameter  int unsigned NUM_SYS = 16,
    parameter  int unsigned PRIO_W  = 2,
    localparam int unsigned NUM_SRC = NUM_EXT + NUM_SYS,
    localparam int unsigned VEC_W   = $clog2(NUM_SRC),
    localparam int unsigned LVL_W   = PRIO_W + 1,
    localparam int unsigned IDLE    = (1 << PRIO_W),
    localparam int unsigned PAD     = (1 << VEC_W)
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_EXT-1:0] ext_req,
    input logic [NUM_SYS-1:0] sys_req,
    input logic               handler_exit,
    input logic               take_pulse,
    input logic [VEC_W-1:0]   take_vec,
    input logic [LVL_W-1:0]   active_lvl
);
    logic [PAD-1:0] req_d;

    always_ff @(posedge clk) begin
        if (rst)
            req_d <= '0;
        else
            req_d <= PAD'({ext_req, sys_req});
    end

    // R5: a taken vector was requesting on the sampling edge
    p_take_from_req_r5: assert property (@(posedge clk) disable iff (rst)
        take_pulse |-> req_d[take_vec]);

    // R7, R8: every entry moves the active level to a strictly more urgent value
    p_take_deepens_r7: assert property (@(posedge clk) disable iff (rst)
        take_pulse |-> (active_lvl < $past(active_lvl)));

    // R10: the edge that samples an exit produces no entry
    p_exit_blocks_take_r10: assert property (@(posedge clk) disable iff (rst)
        handler_exit |=> !take_pulse);

    // R9: an exit from a running handler returns to a less urgent level
    p_exit_restores_r9: assert property (@(posedge clk) disable iff (rst)
        (handler_exit && (active_lvl != LVL_W'(IDLE))) |=> (active_lvl > $past(active_lvl)));

    // R9: an exit with nothing running keeps the idle level
    p_idle_exit_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (handler_exit && (active_lvl == LVL_W'(IDLE))) |=> (active_lvl == LVL_W'(IDLE)));

endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(
    .NUM_EXT (NUM_EXT),
    .NUM_SYS (NUM_SYS),
    .PRIO_W  (PRIO_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ext_req      (ext_req),
    .sys_req      (sys_req),
    .handler_exit (handler_exit),
    .take_pulse   (take_pulse),
    .take_vec     (take_vec),
    .active_lvl   (active_lvl)
);

// File: tb/irq_prio_arbiter_tb.sv
module irq_prio_arbiter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] ext_req = '0;
    logic [15:0] sys_req = '0;
    logic        handler_exit = 1'b0;
    logic        take_pulse;
    logic [5:0]  take_vec;
    logic [2:0]  active_lvl;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_prio_arbiter u_dut (
        .clk          (clk),
        .rst          (rst),
        .bus_we       (bus_we),
        .bus_be       (bus_be),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .ext_req      (ext_req),
        .sys_req      (sys_req),
        .handler_exit (handler_exit),
        .take_pulse   (take_pulse),
        .take_vec     (take_vec),
        .active_lvl   (active_lvl)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    // Expect the outputs at the next falling edge
    task automatic expect_out(input string tag, input logic tk, input logic [5:0] v, input logic [2:0] lvl);
        @(negedge clk);
        chk({tag, " take"}, 32'(take_pulse), 32'(tk));
        if (tk) chk({tag, " vec"}, 32'(take_vec), 32'(v));
        chk({tag, " lvl"}, 32'(active_lvl), 32'(lvl));
    endtask

    task automatic t_reset;
        chk("R1 idle level", 32'(active_lvl), 32'd4);
        chk("R1 take low", 32'(take_pulse), 32'd0);
        for (int w = 0; w < 12; w++)
            rd_chk("R1 word zero", 4'(w), 32'h0);
    endtask

    task automatic t_field_width;
        wr(4'd0, 32'hFFC08040, 4'hF);
        rd_chk("R2 top bits kept", 4'd0, 32'hFFC08040 & 32'hC0C0C0C0);
        wr(4'd1, 32'h3F3F3F3F, 4'hF);
        rd_chk("R2 low bits dropped", 4'd1, 32'h0);
        wr(4'd5, 32'h12345678, 4'hF);
        rd_chk("R2 mixed word", 4'd5, 32'h00004040);
    endtask

    task automatic t_partial;
        wr(4'd0, 32'h00000000, 4'h1);
        rd_chk("R3 byte write ignored", 4'd0, 32'hC0C08040);
        wr(4'd0, 32'h00000000, 4'hE);
        rd_chk("R3 three-byte write ignored", 4'd0, 32'hC0C08040);
        wr(4'd0, 32'h00000000, 4'h3);
        rd_chk("R3 halfword write ignored", 4'd0, 32'hC0C08040);
    endtask

    task automatic t_map;
        wr(4'd11, 32'h40000000, 4'hF);
        rd_chk("R4 tick word", 4'd11, 32'h40000000);
        wr(4'd12, 32'hFFFFFFFF, 4'hF);
        rd_chk("R4 index 12 zero", 4'd12, 32'h0);
        rd_chk("R4 index 15 zero", 4'd15, 32'h0);
        rd_chk("R4 neighbour untouched", 4'd10, 32'h0);
        // ext0=2, ext1=1, ext2=1, ext3=3; ext4..7=0
        wr(4'd0, 32'hC0404080, 4'hF);
        wr(4'd5, 32'h0, 4'hF);
    endtask

    task automatic t_single;
        @(negedge clk);
        ext_req = 32'h1;
        expect_out("R5 single ext0", 1'b1, 6'd16, 3'd2);
        expect_out("R5 pulse one cycle", 1'b0, 6'd0, 3'd2);
        ext_req = '0; handler_exit = 1'b1;
        expect_out("R9 exit to idle", 1'b0, 6'd0, 3'd4);
        handler_exit = 1'b0;
    endtask

    task automatic t_tie;
        ext_req = 32'h6;
        expect_out("R6 tie ext1 ext2", 1'b1, 6'd17, 3'd1);
        ext_req = '0; handler_exit = 1'b1;
        expect_out("R9 exit after tie", 1'b0, 6'd0, 3'd4);
        handler_exit = 1'b0;
        ext_req = 32'h4; sys_req = 16'h8000;
        expect_out("R6 R4 tick beats ext2", 1'b1, 6'd15, 3'd1);
        ext_req = '0; sys_req = '0; handler_exit = 1'b1;
        expect_out("R9 exit after tick", 1'b0, 6'd0, 3'd4);
        handler_exit = 1'b0;
        ext_req = 32'h10; sys_req = 16'h0001; // ext4 and sys0 both level 0
        expect_out("R6 sys0 over ext4", 1'b1, 6'd0, 3'd0);
        ext_req = '0; sys_req = '0; handler_exit = 1'b1;
        expect_out("R9 exit after sys0", 1'b0, 6'd0, 3'd4);
        handler_exit = 1'b0;
    endtask

    task automatic t_nest;
        ext_req = 32'h8;
        expect_out("R8 enter ext3", 1'b1, 6'd19, 3'd3);
        ext_req = 32'h9;
        expect_out("R7 ext0 preempts", 1'b1, 6'd16, 3'd2);
        ext_req = 32'hB;
        expect_out("R7 ext1 preempts", 1'b1, 6'd17, 3'd1);
        ext_req = 32'hF;
        for (int c = 0; c < 3; c++)
            expect_out("R7 equal level waits", 1'b0, 6'd0, 3'd1);
        ext_req = 32'h4; handler_exit = 1'b1;
        expect_out("R10 R9 exit edge no take", 1'b0, 6'd0, 3'd2);
        handler_exit = 1'b0;
        expect_out("R10 waiting ext2 taken", 1'b1, 6'd18, 3'd1);
        ext_req = '0; handler_exit = 1'b1;
        expect_out("R9 pop to 2", 1'b0, 6'd0, 3'd2);
        expect_out("R9 pop to 3", 1'b0, 6'd0, 3'd3);
        expect_out("R9 pop to idle", 1'b0, 6'd0, 3'd4);
        expect_out("R9 empty exit ignored", 1'b0, 6'd0, 3'd4);
        handler_exit = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_field_width();
        t_partial();
        t_map();
        t_single();
        t_tie();
        t_nest();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule